// File: doc/BRIEF.md
# GPIO Bank Register File

This block is the register side of a general-purpose I/O controller serving up to 94 pins. A host reaches it over a plain 32-bit read/write bus with word addresses. Two address schemes share the block. The first is a set of bank words in which each word carries one bit for each of 32 pins; these cover pin ownership, interrupt status and interrupt enable. The second is a pair of configuration words for every pin, placed one after another.

From the configuration words the block drives each pad's output level and output enable, its weak-pull code, and whether the pin runs as a GPIO or hands over to its native function. It also passes each pin's trigger style on to external event detectors. Pad inputs are brought into the clock domain by a two-flop synchroniser, and each pin's sensing can be disabled. Firmware supplies the ownership map as a fixed vector, which software reads but cannot write. Events from the detectors are latched in the status words. A single interrupt request is raised while any latched event is also enabled, and a global control word chooses which of two interrupt lines carries that request.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every configuration word reads 0 except that the sensing-disable bit (second word, bit 2) reads 1. Status, enable and line-select read 0, and `pad_oe`, `irq_out`, `irq_line_sel`, `sense_level` and `bus_rdata` are all 0.
- R2: The first pin word sits at 0x100 + 8·pin. Its writable bits are 31 (output level), 4 (1 = level trigger), 3 (trigger invert), 2 (1 = input) and 0 (1 = GPIO). Bit 30 returns the sensed input level, and every other bit reads 0.
- R3: The second pin word sits at 0x104 + 8·pin. Bit 2 disables sensing and bits 1:0 hold the pull code, which appears on `pad_pull[2·pin+1:2·pin]`. All other bits read 0.
- R4: `pad_out[p]` follows bit 31, and `pin_gpio_mode[p]` follows bit 0. `pad_oe[p]` is 1 only when bit 0 is 1 and bit 2 is 0, and it changes only after a bus write.
- R5: `sense_level[p]` and read bit 30 equal `pad_in[p]` delayed by two clock edges while sensing is enabled. While sensing is disabled they read 0.
- R6: The ownership words at 0x00, 0x04 and 0x08 return `fw_owner_map` 32 pins per word, with bit p%32 for pin p. Writes to these words change nothing.
- R7: The word at 0x7C holds one bit (bit 0), which drives `irq_line_sel` (0 = first line, 1 = second line). Its other bits read 0.
- R8: The status words at 0x80, 0x84 and 0x88 set a bit one edge after `int_event` is high for that pin. Writing 1 to a bit clears it. If an event and a clear meet in the same cycle, the event wins.
- R9: The enable words at 0x90, 0x94 and 0x98 are read/write. Bits for pins at 94 and above read 0. `irq_out` is 1 exactly while some status bit and its enable bit are both 1.
- R10: Reads of unmapped offsets return 0, and writes to them change no state. This covers pin words at or beyond pin 94, the gap 0x0C–0x7B and offsets from 0xA0 up to 0xFF.
- R11: `bus_rdata` loads the addressed word on the edge where `bus_rd_en` is 1 and holds its value at every other time.
- R12: `trig_level[p]` and `trig_invert[p]` follow bits 4 and 3 of the pin's first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| fw_owner_map | input | 94 | Firmware ownership map, 0 = reserved by firmware |
| pad_in | input | 94 | Asynchronous pad input levels |
| int_event | input | 94 | Event pulses from the external detectors |
| pad_out | output | 94 | Pad output levels |
| pad_oe | output | 94 | Pad output enables |
| pad_pull | output | 188 | Weak-pull code, two bits per pin |
| pin_gpio_mode | output | 94 | 1 = pin runs as GPIO, 0 = native function |
| trig_level | output | 94 | Trigger style for the detectors, 1 = level |
| trig_invert | output | 94 | Trigger inversion for the detectors |
| sense_level | output | 94 | Synchronised, gated input level for the detectors |
| irq_out | output | 1 | Combined interrupt request |
| irq_line_sel | output | 1 | Selects which of two interrupt lines carries the request |

## Verification
A write's effect on the pad outputs, the trigger outputs, `irq_line_sel` and the enable-driven part of `irq_out` is visible right after the clock edge that takes the write. Read data appears after the edge that takes the read. A status bit, and the `irq_out` it causes, appears one edge after its event. A pad change reaches `sense_level` and read bit 30 after the second edge. The bench drives stimulus on falling edges and samples on the next falling edge, or for the synchroniser on each of the next two, so that every check lands at a fixed offset from the edge that should cause the result.

// File: rtl/gpio_bank_pkg.sv
// Shared constants, the per-pin configuration type and the word-packing
// helpers for the GPIO bank register file.
// Assumes 12-bit byte addresses and 32-bit data words.
package gpio_bank_pkg;

    localparam int OFS_OWNER   = 'h000;
    localparam int OFS_LINESEL = 'h07C;
    localparam int OFS_STAT    = 'h080;
    localparam int OFS_EN      = 'h090;
    localparam int OFS_PIN     = 'h100;

    // Bit positions inside the first per-pin word
    localparam int C1_OUT  = 31;
    localparam int C1_IN   = 30;
    localparam int C1_TRIG = 4;
    localparam int C1_INV  = 3;
    localparam int C1_DIR  = 2;
    localparam int C1_SEL  = 0;
    // Bit positions inside the second per-pin word
    localparam int C2_NOSENSE = 2;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0,
        trig_inv: 1'b0, dir_in: 1'b0, use_gpio: 1'b0, sense_off: 1'b1,
        pull: 2'b00};

    function automatic logic [31:0] cfg1_word(pin_cfg_t c, logic in_lvl);
        logic [31:0] w;
        w          = '0;
        w[C1_OUT]  = c.out_lvl;
        w[C1_IN]   = in_lvl;
        w[C1_TRIG] = c.trig_lvl;
        w[C1_INV]  = c.trig_inv;
        w[C1_DIR]  = c.dir_in;
        w[C1_SEL]  = c.use_gpio;
        return w;
    endfunction

    function automatic logic [31:0] cfg2_word(pin_cfg_t c);
        logic [31:0] w;
        w             = '0;
        w[C2_NOSENSE] = c.sense_off;
        w[1:0]        = c.pull;
        return w;
    endfunction

endpackage

// File: rtl/gpio_pin_cfg.sv
// Holds the two configuration words of one pin.
// Assumes the write strobes are already decoded to this pin and word.
module gpio_pin_cfg
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_c1,
    input  logic        wr_c2,
    input  logic [31:0] wdata,
    output pin_cfg_t    cfg
);

    // Load the writable fields of either word; reset to the idle configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= PIN_CFG_RST;
        end else begin
            if (wr_c1) begin
                cfg.out_lvl  <= wdata[C1_OUT];
                cfg.trig_lvl <= wdata[C1_TRIG];
                cfg.trig_inv <= wdata[C1_INV];
                cfg.dir_in   <= wdata[C1_DIR];
                cfg.use_gpio <= wdata[C1_SEL];
            end
            if (wr_c2) begin
                cfg.sense_off <= wdata[C2_NOSENSE];
                cfg.pull      <= wdata[1:0];
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_in_sync #(
    parameter int WIDTH = 94
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    // Shift the pad levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// One 32-pin word of interrupt status (set by event, write-1-to-clear)
// and interrupt enable. Bits at LIVE_BITS and above stay 0.
// Assumes 1 <= LIVE_BITS <= 32.
module gpio_irq_bank #(
    parameter int LIVE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_wr,
    input  logic        stat_clr,
    input  logic [31:0] wdata,
    input  logic [31:0] event_in,
    output logic [31:0] stat,
    output logic [31:0] en
);

    localparam logic [31:0] LIVE_MASK = (LIVE_BITS >= 32) ? 32'hFFFF_FFFF :
                                        32'((64'd1 << LIVE_BITS) - 64'd1);

    logic [31:0] clr_bits;

    // Bits the current write asks to clear
    always_comb clr_bits = stat_clr ? wdata : 32'h0;

    // Update enables on write; latch events, clearing on write-1, event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else begin
            if (en_wr) en <= wdata & LIVE_MASK;
            stat <= ((stat & ~clr_bits) | event_in) & LIVE_MASK;
        end
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// GPIO bank register file: decodes bank words and per-pin word pairs,
// returns registered read data, and drives the pad and detector controls.
// Assumes word-aligned addresses (bits 1:0 ignored), NUM_PINS <= 128 so the
// bank words fit four per region, and one access per cycle.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   fw_owner_map,
    input  logic [NUM_PINS-1:0]   pad_in,
    input  logic [NUM_PINS-1:0]   int_event,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pad_pull,
    output logic [NUM_PINS-1:0]   pin_gpio_mode,
    output logic [NUM_PINS-1:0]   trig_level,
    output logic [NUM_PINS-1:0]   trig_invert,
    output logic [NUM_PINS-1:0]   sense_level,
    output logic                  irq_out,
    output logic                  irq_line_sel
);

    localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam int PAD_W     = NUM_WORDS * 32;
    localparam logic [ADDR_W-1:0] A_OWNER   = ADDR_W'(OFS_OWNER);
    localparam logic [ADDR_W-1:0] A_LINESEL = ADDR_W'(OFS_LINESEL);
    localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_EN      = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_PIN     = ADDR_W'(OFS_PIN);

    logic [ADDR_W-1:0] word_base;
    logic [1:0]        word_idx;
    logic              hit_owner, hit_stat, hit_en, hit_linesel;
    logic [ADDR_W-1:0] pin_off, pin_idx;
    logic              pin_hit;
    logic [31:0]       rd_mux;
    logic              line_sel_q;

    pin_cfg_t          cfg [NUM_PINS];
    logic [NUM_PINS-1:0] sense_off_v;
    logic [NUM_PINS-1:0] pad_sync;
    logic [PAD_W-1:0]  owner_pad, event_pad;
    logic [31:0]       owner_w [NUM_WORDS];
    logic [31:0]       stat_w  [NUM_WORDS];
    logic [31:0]       en_w    [NUM_WORDS];
    logic [NUM_WORDS-1:0] pending_w;

    // Address decode for bank words and per-pin word pairs
    always_comb begin
        word_base   = {bus_addr[ADDR_W-1:4], 4'b0000};
        word_idx    = bus_addr[3:2];
        hit_owner   = (word_base == A_OWNER);
        hit_stat    = (word_base == A_STAT);
        hit_en      = (word_base == A_EN);
        hit_linesel = (bus_addr[ADDR_W-1:2] == A_LINESEL[ADDR_W-1:2]);
        pin_off     = bus_addr - A_PIN;
        pin_idx     = pin_off >> 3;
        pin_hit     = (bus_addr >= A_PIN) && (int'(pin_idx) < NUM_PINS);
    end

    assign owner_pad = PAD_W'(fw_owner_map);
    assign event_pad = PAD_W'(int_event);

    // Pad input synchroniser feeding the sensed level
    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    assign sense_level = pad_sync & ~sense_off_v;

    // One configuration pair per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel;
        assign sel = pin_hit && (pin_idx == ADDR_W'(p));

        gpio_pin_cfg u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_c1 (bus_wr_en && sel && !bus_addr[2]),
            .wr_c2 (bus_wr_en && sel && bus_addr[2]),
            .wdata (bus_wdata),
            .cfg   (cfg[p])
        );

        assign pad_out[p]         = cfg[p].out_lvl;
        assign pad_oe[p]          = cfg[p].use_gpio && !cfg[p].dir_in;
        assign pin_gpio_mode[p]   = cfg[p].use_gpio;
        assign trig_level[p]      = cfg[p].trig_lvl;
        assign trig_invert[p]     = cfg[p].trig_inv;
        assign sense_off_v[p]     = cfg[p].sense_off;
        assign pad_pull[2*p +: 2] = cfg[p].pull;
    end

    // One status/enable word per group of 32 pins
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int LIVE = (NUM_PINS - w*32 >= 32) ? 32 : NUM_PINS - w*32;

        gpio_irq_bank #(.LIVE_BITS(LIVE)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_wr    (bus_wr_en && hit_en && (word_idx == 2'(w))),
            .stat_clr (bus_wr_en && hit_stat && (word_idx == 2'(w))),
            .wdata    (bus_wdata),
            .event_in (event_pad[w*32 +: 32]),
            .stat     (stat_w[w]),
            .en       (en_w[w])
        );

        assign owner_w[w]   = owner_pad[w*32 +: 32];
        assign pending_w[w] = |(stat_w[w] & en_w[w]);
    end

    assign irq_out      = |pending_w;
    assign irq_line_sel = line_sel_q;

    // Global interrupt-line select register
    always_ff @(posedge clk) begin
        if (!rst_n)                       line_sel_q <= 1'b0;
        else if (bus_wr_en && hit_linesel) line_sel_q <= bus_wdata[0];
    end

    // Read-back multiplexer; unmapped offsets yield 0
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(word_idx) == w) begin
                if (hit_owner) rd_mux = owner_w[w];
                if (hit_stat)  rd_mux = stat_w[w];
                if (hit_en)    rd_mux = en_w[w];
            end
        end
        if (hit_linesel) rd_mux = {31'b0, line_sel_q};
        if (pin_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (int'(pin_idx) == p)
                    rd_mux = bus_addr[2] ? cfg2_word(cfg[p])
                                         : cfg1_word(cfg[p], sense_level[p]);
            end
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
// Assertion checker for the GPIO bank register file, attached by bind.
// Assumes the same synchronous active-low reset as the design.
module gpio_bank_regs_chk #(
    parameter int NUM_PINS = 94
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_en,
    input logic                bus_rd_en,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] int_event,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] sense_level,
    input logic                irq_out,
    input logic                irq_line_sel
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0) && !irq_out && !irq_line_sel && (bus_rdata == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

    // R5
    sense_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_level[0] |-> $past(pad_in[0], 2));

    // R4
    oe_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> $past(bus_wr_en));

    // R7
    linesel_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_line_sel) |-> $past(bus_wr_en));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(bus_wr_en) || $past(|int_event)));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_rdata    (bus_rdata),
    .pad_in       (pad_in),
    .int_event    (int_event),
    .pad_oe       (pad_oe),
    .sense_level  (sense_level),
    .irq_out      (irq_out),
    .irq_line_sel (irq_line_sel)
);

// File: tb/gpio_bank_regs_tb_top.sv
// Self-checking bench: a vector table of bus accesses, then directed tests.
module gpio_bank_regs_tb_top;

    localparam int NP = 94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] fw_owner_map = {30'h2BCDEF01, 32'h12345678, 32'hA5A50F0F};
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] int_event = '0;
    logic [NP-1:0] pad_out, pad_oe, pin_gpio_mode, trig_level, trig_invert, sense_level;
    logic [2*NP-1:0] pad_pull;
    logic          irq_out, irq_line_sel;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    gpio_bank_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fw_owner_map(fw_owner_map), .pad_in(pad_in), .int_event(int_event),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pin_gpio_mode(pin_gpio_mode), .trig_level(trig_level),
        .trig_invert(trig_invert), .sense_level(sense_level),
        .irq_out(irq_out), .irq_line_sel(irq_line_sel)
    );

    // {req[3:0], write, addr[11:0], data/expected[31:0]}
    localparam int NV = 25;
    localparam logic [48:0] VEC [NV] = '{
        {4'd6,  1'b0, 12'h000, 32'hA5A50F0F},  // R6 word 0
        {4'd6,  1'b1, 12'h004, 32'hFFFFFFFF},  // R6 write ignored
        {4'd6,  1'b0, 12'h004, 32'h12345678},  // R6
        {4'd6,  1'b0, 12'h008, 32'h2BCDEF01},  // R6 last word
        {4'd2,  1'b1, 12'h100, 32'hFFFFFFFF},  // R2 pin 0 first word
        {4'd2,  1'b0, 12'h100, 32'h8000001D},  // R2 only writable bits
        {4'd3,  1'b1, 12'h104, 32'hFFFFFFFF},  // R3
        {4'd3,  1'b0, 12'h104, 32'h00000007},  // R3
        {4'd3,  1'b1, 12'h104, 32'h00000002},  // R3 sensing on, pull 2
        {4'd3,  1'b0, 12'h104, 32'h00000002},  // R3
        {4'd2,  1'b1, 12'h3E8, 32'h80000001},  // R2 pin 93
        {4'd2,  1'b0, 12'h3E8, 32'h80000001},  // R2
        {4'd10, 1'b1, 12'h3F0, 32'hFFFFFFFF},  // R10 pin 94 absent
        {4'd10, 1'b0, 12'h3F0, 32'h00000000},  // R10
        {4'd10, 1'b0, 12'h00C, 32'h00000000},  // R10 gap
        {4'd10, 1'b1, 12'h0A0, 32'hFFFFFFFF},  // R10
        {4'd10, 1'b0, 12'h0A0, 32'h00000000},  // R10
        {4'd9,  1'b1, 12'h098, 32'hFFFFFFFF},  // R9 last enable word
        {4'd9,  1'b0, 12'h098, 32'h3FFFFFFF},  // R9 only 30 live bits
        {4'd9,  1'b1, 12'h090, 32'h00000101},  // R9
        {4'd9,  1'b0, 12'h090, 32'h00000101},  // R9
        {4'd7,  1'b1, 12'h07C, 32'hFFFFFFFF},  // R7
        {4'd7,  1'b0, 12'h07C, 32'h00000001},  // R7 one bit only
        {4'd7,  1'b1, 12'h07C, 32'h00000000},  // R7
        {4'd7,  1'b0, 12'h07C, 32'h00000000}   // R7
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic do_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", bus_rdata, 0);
        check("R1 pad_oe", 32'(|pad_oe), 0);
        check("R1 irq_out", 32'(irq_out), 0);
        check("R1 line_sel", 32'(irq_line_sel), 0);
        check("R1 sense", 32'(|sense_level), 0);
        do_read(12'h104, rd); check("R1 cfg2 reset", rd, 32'h4);
        do_read(12'h100, rd); check("R1 cfg1 reset", rd, 32'h0);
        do_read(12'h090, rd); check("R1 enable reset", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                do_write(VEC[i][43:32], VEC[i][31:0]);
            end else begin
                do_read(VEC[i][43:32], rd);
                check($sformatf("R%0d vec%0d", VEC[i][48:45], i), rd, VEC[i][31:0]);
            end
        end
        check("R3 pull pin0", 32'(pad_pull[1:0]), 32'h2);
        check("R4 oe pin93", 32'(pad_oe[93]), 1);
        check("R4 gpio mode pin93", 32'(pin_gpio_mode[93]), 1);
        check("R4 oe pin0 input", 32'(pad_oe[0]), 0);

        // R4 / R12 pin 5 pad control
        do_write(12'h128, 32'h80000001);
        check("R4 oe pin5", 32'(pad_oe[5]), 1);
        check("R4 out pin5", 32'(pad_out[5]), 1);
        do_write(12'h128, 32'h00000005);
        check("R4 oe pin5 input", 32'(pad_oe[5]), 0);
        check("R4 out pin5 low", 32'(pad_out[5]), 0);
        do_write(12'h128, 32'h00000018);
        check("R12 trig_level", 32'(trig_level[5]), 1);
        check("R12 trig_invert", 32'(trig_invert[5]), 1);
        check("R4 native mode", 32'(pin_gpio_mode[5]), 0);

        // R5 input synchroniser and sensing gate, pin 7
        do_write(12'h13C, 32'h0);
        pad_in[7] = 1'b1;
        @(negedge clk);
        check("R5 one edge", 32'(sense_level[7]), 0);
        @(negedge clk);
        check("R5 two edges", 32'(sense_level[7]), 1);
        do_read(12'h138, rd); check("R5 read bit30", rd, 32'h40000000);
        do_write(12'h13C, 32'h4);
        check("R5 sensing off", 32'(sense_level[7]), 0);
        do_read(12'h138, rd); check("R5 read off", rd, 32'h0);

        // R8 / R9 status and interrupt, pin 3
        do_write(12'h090, 32'h00000108);
        @(negedge clk); int_event[3] = 1'b1;
        @(negedge clk); int_event[3] = 1'b0;
        check("R8 irq after event", 32'(irq_out), 1);
        do_read(12'h080, rd); check("R8 status set", rd, 32'h8);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 12'h080; bus_wdata = 32'h8; int_event[3] = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; int_event[3] = 1'b0;
        do_read(12'h080, rd); check("R8 event wins", rd, 32'h8);
        do_write(12'h080, 32'h8);
        check("R8 cleared irq", 32'(irq_out), 0);
        do_read(12'h080, rd); check("R8 cleared", rd, 32'h0);
        @(negedge clk); int_event[41] = 1'b1;
        @(negedge clk); int_event[41] = 1'b0;
        check("R9 disabled no irq", 32'(irq_out), 0);
        do_read(12'h084, rd); check("R9 status word1", rd, 32'h200);

        // R11 read data holds without a read strobe
        do_read(12'h000, held);
        repeat (3) @(negedge clk);
        check("R11 hold idle", bus_rdata, held);
        do_write(12'h07C, 32'h1);
        check("R11 hold on write", bus_rdata, held);
        check("R7 line_sel", 32'(irq_line_sel), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule